// File: doc/BRIEF.md
# Dual-Channel PCM Serial Port

This block moves two voice channels of 8-bit samples across a frame-synchronised serial link. A single bit clock times every slot. Receive and transmit each have their own frame sync pulse, so the two directions can be offset from each other by any number of slots. A lane-select pin picks one of two layouts. In parallel layout each channel has its own data pin in each direction. In serial layout both channels travel on one pin per direction as two back-to-back bytes, with channel 1 first.

On the core side, each received byte appears on its own bus with a single-cycle strobe. The bytes to be sent are taken from two input buses at the moment the transmit frame starts. The transmit pins come with output enables for an external tri-state or open-drain driver. The block runs directly on the bit clock: transmit bits change on the rising edge and receive bits are sampled on the falling edge.

Top module: `dual_pcm_port`

## Requirements
- R1: While `rst` is high at a rising edge, all output enables, transmit pins and strobes are low from that edge, and both received-byte buses read 0.
- R2: A rising edge that samples `tx_sync` high latches `tx_byte1` and `tx_byte2`, raises `tx_oe1`, and puts bit 7 of the first transmitted byte on `tx_pin1` for the slot that starts on that edge. Changes on the byte inputs after that edge do not alter the frame.
- R3: With `lane_sel` = 1 latched at the transmit sync, `tx_pin1` carries `tx_byte1` and `tx_pin2` carries `tx_byte2`, both MSB first over slots 0 to 7, with both enables high in those slots only.
- R4: With `lane_sel` = 0 latched at the transmit sync, `tx_pin1` carries `tx_byte1` then `tx_byte2`, MSB first, over slots 0 to 15, and `tx_oe2` stays low.
- R5: With `lane_sel` = 1 latched at the receive sync, the bit on `rx_pin1` (channel 1) and the bit on `rx_pin2` (channel 2) are each taken at the falling edge inside slots 0 to 7, MSB first. Both bytes appear on `rx_byte1` and `rx_byte2`, with `rx_stb1` and `rx_stb2` high for one cycle, starting at the rising edge that ends slot 7.
- R6: With `lane_sel` = 0 latched at the receive sync, `rx_pin2` alone is read for 16 slots. Slots 0 to 7 form `rx_byte1` and raise `rx_stb1` after slot 7. Slots 8 to 15 form `rx_byte2` and raise `rx_stb2` after slot 15. `rx_pin1` is ignored.
- R7: Each direction latches `lane_sel` at its own sync. Changes to `lane_sel` during a frame do not affect that frame.
- R8: A sync that arrives while a frame is still running restarts that direction at slot 0. This also holds when the sync falls on the edge that completes the last slot, in which case that last slot's byte is still delivered.
- R9: Receive timing depends only on `rx_sync`, and transmit timing only on `tx_sync`.
- R10: Whenever an output enable is low, the matching transmit pin is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one rising edge per slot |
| rst | input | 1 | Synchronous active-high reset |
| tx_sync | input | 1 | Transmit frame start, high for one slot |
| rx_sync | input | 1 | Receive frame start, high for one slot |
| lane_sel | input | 1 | 1 = one pin per channel, 0 = both channels on one pin |
| rx_pin1 | input | 1 | Receive data pin 1 |
| rx_pin2 | input | 1 | Receive data pin 2 |
| tx_byte1 | input | 8 | Channel 1 sample to send |
| tx_byte2 | input | 8 | Channel 2 sample to send |
| tx_pin1 | output | 1 | Transmit data pin 1 |
| tx_oe1 | output | 1 | Drive enable for transmit pin 1 |
| tx_pin2 | output | 1 | Transmit data pin 2 |
| tx_oe2 | output | 1 | Drive enable for transmit pin 2 |
| rx_byte1 | output | 8 | Last channel 1 byte received |
| rx_stb1 | output | 1 | One-cycle strobe for rx_byte1 |
| rx_byte2 | output | 8 | Last channel 2 byte received |
| rx_stb2 | output | 1 | One-cycle strobe for rx_byte2 |

## Verification
Two events can land on the same rising edge: the completion of a frame's last slot, with its byte strobe or final transmit bit, and the start of the next frame. The bench provokes this by running 8-slot parallel frames back to back with sync pulses every 8 cycles in both directions. It also issues serial-mode syncs every 10 cycles, which cut frames short. A behavioural model built from queues and integers predicts every pin, enable, strobe and byte on every cycle. The bench judges that the finished byte is still delivered and that the new frame starts with a freshly latched MSB.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    localparam int SAMPLE_W = 8;
    localparam int CHANNELS = 2;
    localparam int FRAME_W  = SAMPLE_W * CHANNELS;
    localparam int SLOT_W   = $clog2(FRAME_W);

    typedef enum logic {
        LANE_SERIAL   = 1'b0,
        LANE_PARALLEL = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
        lane_mode_e        mode;
    } frame_pos_t;

    function automatic logic [SLOT_W-1:0] last_slot(lane_mode_e m);
        return (m == LANE_PARALLEL) ? SLOT_W'(SAMPLE_W - 1) : SLOT_W'(FRAME_W - 1);
    endfunction
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync,
    input  logic       mode_pin,
    output frame_pos_t pos
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '{active: 1'b0, slot: '0, mode: LANE_SERIAL};
        end else if (sync) begin
            pos.active <= 1'b1;
            pos.slot   <= '0;
            pos.mode   <= lane_mode_e'(mode_pin);
        end else if (pos.active) begin
            if (pos.slot == last_slot(pos.mode)) begin
                pos.active <= 1'b0;
            end else begin
                pos.slot <= pos.slot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_rx_deframer.sv
module pcm_rx_deframer
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  frame_pos_t          pos,
    input  logic                rx_pin1,
    input  logic                rx_pin2,
    output logic [SAMPLE_W-1:0] rx_byte1,
    output logic                rx_stb1,
    output logic [SAMPLE_W-1:0] rx_byte2,
    output logic                rx_stb2
);
    localparam logic [SLOT_W-1:0] END_A = SLOT_W'(SAMPLE_W - 1);
    localparam logic [SLOT_W-1:0] END_B = SLOT_W'(FRAME_W - 1);

    logic                bit1_q, bit2_q;
    logic [SAMPLE_W-1:0] acc1, acc2, nxt1, nxt2;
    logic                par, first_half;

    // Pins are read mid-slot, on the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            bit1_q <= 1'b0;
            bit2_q <= 1'b0;
        end else begin
            bit1_q <= rx_pin1;
            bit2_q <= rx_pin2;
        end
    end

    always_comb begin
        par        = (pos.mode == LANE_PARALLEL);
        first_half = (pos.slot < SLOT_W'(SAMPLE_W));
        nxt1       = {acc1[SAMPLE_W-2:0], par ? bit1_q : bit2_q};
        nxt2       = {acc2[SAMPLE_W-2:0], bit2_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc1     <= '0;
            acc2     <= '0;
            rx_byte1 <= '0;
            rx_byte2 <= '0;
            rx_stb1  <= 1'b0;
            rx_stb2  <= 1'b0;
        end else begin
            rx_stb1 <= 1'b0;
            rx_stb2 <= 1'b0;
            if (pos.active) begin
                if (par) begin
                    acc1 <= nxt1;
                    acc2 <= nxt2;
                    if (pos.slot == END_A) begin
                        rx_byte1 <= nxt1;
                        rx_byte2 <= nxt2;
                        rx_stb1  <= 1'b1;
                        rx_stb2  <= 1'b1;
                    end
                end else if (first_half) begin
                    acc1 <= nxt1;
                    if (pos.slot == END_A) begin
                        rx_byte1 <= nxt1;
                        rx_stb1  <= 1'b1;
                    end
                end else begin
                    acc2 <= nxt2;
                    if (pos.slot == END_B) begin
                        rx_byte2 <= nxt2;
                        rx_stb2  <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sync,
    input  logic                active,
    input  lane_mode_e          mode,
    input  logic [SAMPLE_W-1:0] tx_byte1,
    input  logic [SAMPLE_W-1:0] tx_byte2,
    output logic                tx_pin1,
    output logic                tx_oe1,
    output logic                tx_pin2,
    output logic                tx_oe2
);
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (sync) begin
            shreg <= {tx_byte1, tx_byte2};
        end else if (active) begin
            if (mode == LANE_PARALLEL) begin
                shreg <= {shreg[FRAME_W-2:SAMPLE_W], 1'b0, shreg[SAMPLE_W-2:0], 1'b0};
            end else begin
                shreg <= {shreg[FRAME_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        tx_oe1  = active;
        tx_oe2  = active && (mode == LANE_PARALLEL);
        tx_pin1 = tx_oe1 & shreg[FRAME_W-1];
        tx_pin2 = tx_oe2 & shreg[SAMPLE_W-1];
    end
endmodule

// File: rtl/dual_pcm_port.sv
module dual_pcm_port
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_sync,
    input  logic                rx_sync,
    input  logic                lane_sel,
    input  logic                rx_pin1,
    input  logic                rx_pin2,
    input  logic [SAMPLE_W-1:0] tx_byte1,
    input  logic [SAMPLE_W-1:0] tx_byte2,
    output logic                tx_pin1,
    output logic                tx_oe1,
    output logic                tx_pin2,
    output logic                tx_oe2,
    output logic [SAMPLE_W-1:0] rx_byte1,
    output logic                rx_stb1,
    output logic [SAMPLE_W-1:0] rx_byte2,
    output logic                rx_stb2
);
    frame_pos_t tx_pos, rx_pos;
    logic       tx_slot_unused;

    pcm_frame_timer u_tx_timer (
        .clk(clk), .rst(rst), .sync(tx_sync), .mode_pin(lane_sel), .pos(tx_pos)
    );

    pcm_frame_timer u_rx_timer (
        .clk(clk), .rst(rst), .sync(rx_sync), .mode_pin(lane_sel), .pos(rx_pos)
    );

    assign tx_slot_unused = ^tx_pos.slot;

    pcm_tx_framer u_framer (
        .clk(clk), .rst(rst), .sync(tx_sync),
        .active(tx_pos.active), .mode(tx_pos.mode),
        .tx_byte1(tx_byte1), .tx_byte2(tx_byte2),
        .tx_pin1(tx_pin1), .tx_oe1(tx_oe1), .tx_pin2(tx_pin2), .tx_oe2(tx_oe2)
    );

    pcm_rx_deframer u_deframer (
        .clk(clk), .rst(rst), .pos(rx_pos),
        .rx_pin1(rx_pin1), .rx_pin2(rx_pin2),
        .rx_byte1(rx_byte1), .rx_stb1(rx_stb1),
        .rx_byte2(rx_byte2), .rx_stb2(rx_stb2)
    );
endmodule

// File: rtl/dual_pcm_port_chk.sv
module dual_pcm_port_chk
    import pcm_port_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                tx_sync,
    input logic                lane_sel,
    input logic [SAMPLE_W-1:0] tx_byte1,
    input logic                tx_pin1,
    input logic                tx_oe1,
    input logic                tx_pin2,
    input logic                tx_oe2,
    input logic                rx_stb1
);
    AST_START_ENABLES: assert property (@(posedge clk) disable iff (rst)
        tx_sync |=> tx_oe1);                                           // R2
    AST_START_MSB: assert property (@(posedge clk) disable iff (rst)
        tx_sync |=> (tx_pin1 == $past(tx_byte1[SAMPLE_W-1])));         // R2
    AST_PIN2_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (rst)
        tx_sync |=> (tx_oe2 == $past(lane_sel)));                      // R7
    AST_PIN2_NEEDS_PIN1: assert property (@(posedge clk) disable iff (rst)
        tx_oe2 |-> tx_oe1);                                            // R4
    AST_QUIET_PIN1: assert property (@(posedge clk) disable iff (rst)
        !tx_oe1 |-> !tx_pin1);                                         // R10
    AST_QUIET_PIN2: assert property (@(posedge clk) disable iff (rst)
        !tx_oe2 |-> !tx_pin2);                                         // R10
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_stb1 |=> !rx_stb1);                                         // R5
endmodule

bind dual_pcm_port dual_pcm_port_chk u_chk (
    .clk(clk), .rst(rst), .tx_sync(tx_sync), .lane_sel(lane_sel),
    .tx_byte1(tx_byte1), .tx_pin1(tx_pin1), .tx_oe1(tx_oe1),
    .tx_pin2(tx_pin2), .tx_oe2(tx_oe2), .rx_stb1(rx_stb1)
);

// File: tb/dual_pcm_port_test.sv
module dual_pcm_port_test;
    import pcm_port_pkg::*;
    localparam int W = SAMPLE_W;
    localparam int F = FRAME_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst = 1'b1, tx_sync = 1'b0, rx_sync = 1'b0, lane_sel = 1'b0;
    logic         rx_pin1 = 1'b0, rx_pin2 = 1'b0;
    logic [W-1:0] tx_byte1 = '0, tx_byte2 = '0;
    logic         tx_pin1, tx_oe1, tx_pin2, tx_oe2, rx_stb1, rx_stb2;
    logic [W-1:0] rx_byte1, rx_byte2;

    dual_pcm_port uut (.*);

    int    checks = 0, errors = 0;
    string tag = "R1";
    bit    done = 0;

    // behavioural reference
    bit           q1[$], q2[$];
    int           rcnt = -1;
    bit           rpar = 0;
    logic [W-1:0] acc1 = '0, acc2 = '0, e_d1 = '0, e_d2 = '0;
    bit           e_v1, e_v2, e_oe1, e_oe2, e_p1, e_p2;

    task automatic check(string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q1.delete(); q2.delete();
            rcnt = -1; acc1 = '0; acc2 = '0; e_d1 = '0; e_d2 = '0;
            e_v1 = 0; e_v2 = 0; e_oe1 = 0; e_oe2 = 0; e_p1 = 0; e_p2 = 0;
        end else begin
            if (tx_sync) begin
                q1.delete(); q2.delete();
                for (int i = W - 1; i >= 0; i--) q1.push_back(tx_byte1[i]);
                for (int i = W - 1; i >= 0; i--) begin
                    if (lane_sel) q2.push_back(tx_byte2[i]);
                    else          q1.push_back(tx_byte2[i]);
                end
            end
            if (q1.size() > 0) begin e_oe1 = 1; e_p1 = q1.pop_front(); end
            else begin e_oe1 = 0; e_p1 = 0; end
            if (q2.size() > 0) begin e_oe2 = 1; e_p2 = q2.pop_front(); end
            else begin e_oe2 = 0; e_p2 = 0; end

            e_v1 = 0; e_v2 = 0;
            if (rcnt >= 0) begin
                if (rpar) begin
                    acc1 = {acc1[W-2:0], rx_pin1};
                    acc2 = {acc2[W-2:0], rx_pin2};
                    if (rcnt == W - 1) begin
                        e_d1 = acc1; e_d2 = acc2; e_v1 = 1; e_v2 = 1; rcnt = -1;
                    end else rcnt++;
                end else begin
                    if (rcnt < W) acc1 = {acc1[W-2:0], rx_pin2};
                    else          acc2 = {acc2[W-2:0], rx_pin2};
                    if (rcnt == W - 1) begin e_d1 = acc1; e_v1 = 1; end
                    if (rcnt == F - 1) begin e_d2 = acc2; e_v2 = 1; rcnt = -1; end
                    else rcnt++;
                end
            end
            if (rx_sync) begin rcnt = 0; rpar = lane_sel; end
        end
        #5;
        check("tx_oe1", W'(tx_oe1), W'(e_oe1));
        check("tx_pin1", W'(tx_pin1), W'(e_p1));
        check("tx_oe2", W'(tx_oe2), W'(e_oe2));
        check("tx_pin2", W'(tx_pin2), W'(e_p2));
        check("rx_stb1", W'(rx_stb1), W'(e_v1));
        check("rx_stb2", W'(rx_stb2), W'(e_v2));
        check("rx_byte1", rx_byte1, e_d1);
        check("rx_byte2", rx_byte2, e_d2);
    end

    task automatic run(int n, int tp, int rp, int roff, bit mode_v, bit jitter);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tx_sync  = (i % tp == 0);
            rx_sync  = ((i + roff) % rp == 0);
            rx_pin1  = 1'($urandom);
            rx_pin2  = 1'($urandom);
            tx_byte1 = W'($urandom);
            tx_byte2 = W'($urandom);
            lane_sel = jitter ? 1'($urandom) : mode_v;
        end
        @(posedge clk); #1;
        tx_sync = 0; rx_sync = 0;
    endtask

    initial begin
        tag = "R1";
        repeat (4) @(posedge clk);
        #1 rst = 0;
        tag = "R2 R3 R5 R9";
        run(72, 12, 10, 3, 1'b1, 1'b0);
        tag = "R4 R6 R9";
        run(100, 20, 18, 5, 1'b0, 1'b0);
        tag = "R7";
        run(120, 17, 19, 2, 1'b0, 1'b1);
        tag = "R8 R5";
        run(64, 8, 8, 0, 1'b1, 1'b0);
        tag = "R8 R6";
        run(60, 10, 10, 4, 1'b0, 1'b0);
        tag = "R10";
        repeat (30) @(posedge clk);
        tag = "R1";
        #1 rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        repeat (2) @(posedge clk);
        #6;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule